// File: doc/BRIEF.md
# Keyboard Interrupt Controller

This block watches a group of active-low keyboard pins and raises one interrupt request toward the CPU when a key event occurs. Each pin passes through a two-flop synchroniser. It takes part in detection only while its enable bit is set, and that same enable bit also switches on the pin's pullup.

Software reaches the block through a small synchronous register bus with two 8-bit registers: a control/status register at address 0 and a pin enable register at address 1. An event sets a pending flag. The flag drives a registered interrupt request unless the mask bit is set. Software clears the flag by writing a 1 to a write-only acknowledge bit.

Two trigger modes are available. In edge-only mode a falling edge sets the flag once. In edge-and-level mode the flag also stays set for as long as any enabled pin is held low. A pin whose input is still low when it is enabled counts as a falling edge, so software can discard that false event by masking, enabling, acknowledging and then unmasking.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x00, address 1 reads 0x00, `pullup_en` is all zero and `irq_out` is low.
- R2: Address 0 layout: bit 3 is the pending flag (read-only), bit 2 is acknowledge (write-only, always reads 0), bit 1 is the mask, bit 0 is the mode (0 = edge only, 1 = edge and level), and bits 7:4 read 0. The mask and mode bits read back as written.
- R3: The enable register at address 1 reads back as written, and `pullup_en` equals its value.
- R4: A high-to-low transition on an enabled pin sets the pending flag two clocks after the synchroniser captures it. Transitions on disabled pins have no effect.
- R5: In edge mode, writing address 0 with bit 2 set clears the pending flag. A write with bit 2 clear leaves the flag unchanged.
- R6: While the mask bit is 1, `irq_out` stays low, and the pending flag still records events.
- R7: `irq_out` equals pending AND NOT mask, delayed by one clock.
- R8: In edge-and-level mode, the pending flag stays set through an acknowledge while any enabled pin is low. Once all enabled pins are high, an acknowledge clears it.
- R9: Enabling a pin whose input is low counts as a falling edge. The sequence mask, enable, acknowledge, unmask discards that event, and `irq_out` stays low throughout.
- R10: If an acknowledge and a new falling edge reach the flag in the same clock, the flag stays set.
- R11: In edge mode, an enabled pin that stays low after an acknowledge does not set the flag again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 = control/status, 1 = enable |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| key_in | input | NPINS | Keyboard pins, active low |
| pullup_en | output | NPINS | Per-pin pullup enable |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `key_in` may change at any time, because it is resynchronised. They also assume that the bus inputs are stable around the rising edge and that only addresses 0 and 1 exist. The bench changes all inputs on the falling clock edge and holds each key pattern for several cycles, so the synchroniser sees clean single steps. The random phases run with the mask clear. This lets the request output be compared with the expected pending flag after every step.

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl #(
  parameter int NPINS = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [0:0]       bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] key_in,
  output logic [NPINS-1:0] pullup_en,
  output logic             irq_out
);
  localparam int PEND_B = 3;
  localparam int ACK_B  = 2;
  localparam int MASK_B = 1;
  localparam int MODE_B = 0;

  logic [NPINS-1:0] sync1, sync2, gated_q, en_q;
  logic [NPINS-1:0] gated;
  logic pend_q, mask_q, mode_q, irq_q;
  logic fall, lvl, ack, wr_ctrl, wr_en;
  logic [DW-1:0] ctrl_rd, en_rd;

  assign gated   = sync2 | ~en_q;
  assign fall    = |(gated_q & ~gated);
  assign lvl     = mode_q & ~(&gated);
  assign wr_ctrl = bus_we & (bus_addr == 1'b0);
  assign wr_en   = bus_we & (bus_addr == 1'b1);
  assign ack     = wr_ctrl & bus_wdata[ACK_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '1;
      sync2   <= '1;
      gated_q <= '1;
      en_q    <= '0;
      pend_q  <= 1'b0;
      mask_q  <= 1'b0;
      mode_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      sync1   <= key_in;
      sync2   <= sync1;
      gated_q <= gated;
      irq_q   <= pend_q & ~mask_q;
      if (fall || lvl) pend_q <= 1'b1;
      else if (ack)    pend_q <= 1'b0;
      if (wr_ctrl) begin
        mask_q <= bus_wdata[MASK_B];
        mode_q <= bus_wdata[MODE_B];
      end
      if (wr_en) en_q <= bus_wdata[NPINS-1:0];
    end
  end

  always_comb begin
    ctrl_rd         = '0;
    ctrl_rd[PEND_B] = pend_q;
    ctrl_rd[MASK_B] = mask_q;
    ctrl_rd[MODE_B] = mode_q;
    en_rd              = '0;
    en_rd[NPINS-1:0]   = en_q;
  end

  assign bus_rdata = bus_addr[0] ? en_rd : ctrl_rd;
  assign pullup_en = en_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/kbd_irq_ctrl_chk.sv
module kbd_irq_ctrl_chk #(
  parameter int NPINS = 8,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [0:0]       bus_addr,
  input logic [DW-1:0]    bus_rdata,
  input logic             irq_out,
  input logic             pend_q,
  input logic             mask_q,
  input logic             mode_q,
  input logic             ack,
  input logic [NPINS-1:0] sync2,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] gated_q
);
  logic new_fall;
  assign new_fall = |(gated_q & ~(sync2 | ~en_q));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 1'b0) |-> (bus_rdata[7:4] == 4'b0 && bus_rdata[2] == 1'b0));

  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && $past(mask_q)) |-> !irq_out);

  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(pend_q));

  p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    new_fall |=> pend_q);

  p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && |(~sync2 & en_q)) |=> pend_q);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !mode_q && !new_fall) |=> !pend_q);

  p_ack_race_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && new_fall) |=> pend_q);
endmodule

bind kbd_irq_ctrl kbd_irq_ctrl_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .pend_q(pend_q), .mask_q(mask_q), .mode_q(mode_q),
  .ack(ack), .sync2(sync2), .en_q(en_q), .gated_q(gated_q)
);

// File: tb/kbd_irq_ctrl_tb.sv
module kbd_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [0:0] bus_addr = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] key_in = 8'hFF;
  logic [7:0] pullup_en;
  logic       irq_out;

  int checks = 0;
  int errors = 0;
  bit watch_irq = 1'b0;
  bit saw_irq = 1'b0;

  always #5 clk = ~clk;

  kbd_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_in(key_in),
    .pullup_en(pullup_en), .irq_out(irq_out)
  );

  always @(negedge clk) if (watch_irq && irq_out) saw_irq = 1'b1;

  function automatic logic exp_fall(input logic [7:0] old_g, input logic [7:0] new_g);
    return |(old_g & ~new_g);
  endfunction

  function automatic logic exp_low(input logic [7:0] g);
    return ~(&g);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_pend(input string tag, input logic exp);
    logic [7:0] v;
    rd(1'b0, v);
    check(tag, {7'b0, v[3]}, {7'b0, exp});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    rd(1'b0, v); check("R1 ctrl", v, 8'h00);
    rd(1'b1, v); check("R1 enable", v, 8'h00);
    check("R1 pullup", pullup_en, 8'h00);
    check("R1 irq", {7'b0, irq_out}, 8'h00);

    // R2 layout, reserved and ack read 0
    wr(1'b0, 8'hFF);
    rd(1'b0, v); check("R2 ctrl readback", v, 8'h03);
    wr(1'b0, 8'h00);
    rd(1'b0, v); check("R2 ctrl cleared", v, 8'h00);

    // R3 enable and pullups
    wr(1'b1, 8'hA5);
    rd(1'b1, v); check("R3 enable readback", v, 8'hA5);
    check("R3 pullup", pullup_en, 8'hA5);

    // R4 disabled pin ignored, enabled pin sets flag
    key_in = 8'hFD; wait_cyc(5);
    chk_pend("R4 disabled pin ignored", 1'b0);
    key_in = 8'hFF; wait_cyc(4);
    // R7 timing: pin0 falls before edge k; flag at k+2; irq at k+3
    @(negedge clk) key_in = 8'hFE;
    wait_cyc(2);
    chk_pend("R4 flag not yet", 1'b0);
    wait_cyc(1);
    chk_pend("R4 flag set", 1'b1);
    check("R7 irq lags flag", {7'b0, irq_out}, 8'h00);
    wait_cyc(1);
    check("R7 irq follows", {7'b0, irq_out}, 8'h01);

    // R5 write without ack keeps flag; ack clears
    wr(1'b0, 8'h00);
    chk_pend("R5 no-ack write", 1'b1);
    wr(1'b0, 8'h04);
    chk_pend("R5 ack clears", 1'b0);
    // R11 pin still low, no retrigger
    wait_cyc(6);
    chk_pend("R11 held low no retrigger", 1'b0);
    key_in = 8'hFF; wait_cyc(4);

    // R6 mask blocks irq, flag still records
    wr(1'b0, 8'h02);
    key_in = 8'hFB; wait_cyc(5);
    chk_pend("R6 flag under mask", 1'b1);
    check("R6 irq blocked", {7'b0, irq_out}, 8'h00);
    wr(1'b0, 8'h00); wait_cyc(1);
    check("R7 irq after unmask", {7'b0, irq_out}, 8'h01);
    wr(1'b0, 8'h06); wait_cyc(1);
    check("R6 remask drops irq", {7'b0, irq_out}, 8'h00);
    wr(1'b0, 8'h00);
    key_in = 8'hFF; wait_cyc(4);

    // R10 ack coincides with new edge
    key_in = 8'hFE; wait_cyc(5);
    chk_pend("R10 setup", 1'b1);
    @(negedge clk) key_in = 8'hDE;   // pin5 enabled, falls before edge k
    @(negedge clk);                  // after k
    bus_addr = 1'b0; bus_we = 1'b1; bus_wdata = 8'h04;
    @(negedge clk);                  // after k+1: ack would land at k+2
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 8'h00;
    chk_pend("R10 edge wins over ack", 1'b1);
    wr(1'b0, 8'h04);
    chk_pend("R10 later ack clears", 1'b0);
    key_in = 8'hFF; wait_cyc(4);

    // R8 level mode
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h01);
    key_in = 8'hFE; wait_cyc(5);
    chk_pend("R8 set", 1'b1);
    wr(1'b0, 8'h05); wait_cyc(2);
    chk_pend("R8 held through ack", 1'b1);
    key_in = 8'hFF; wait_cyc(4);
    chk_pend("R8 stays until ack", 1'b1);
    wr(1'b0, 8'h05);
    chk_pend("R8 ack clears when high", 1'b0);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);

    // R9 false event on enable discarded
    key_in = 8'hFB; wait_cyc(4);
    watch_irq = 1'b1; saw_irq = 1'b0;
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h04);
    wait_cyc(3);
    chk_pend("R9 enable of low pin is edge", 1'b1);
    wr(1'b0, 8'h06);
    wr(1'b0, 8'h00);
    wait_cyc(6);
    chk_pend("R9 flag discarded", 1'b0);
    watch_irq = 1'b0;
    check("R9 irq never rose", {7'b0, saw_irq}, 8'h00);
    key_in = 8'hFF; wait_cyc(4);

    // Random phases: mode 0 then mode 1
    for (int ph = 0; ph < 2; ph++) begin
      logic [7:0] en, old_g, new_g, k;
      logic pend;
      en = 8'($urandom) | 8'h01;
      key_in = 8'hFF; wait_cyc(4);
      wr(1'b0, 8'h02 | 8'(ph));
      wr(1'b1, en);
      wait_cyc(4);
      wr(1'b0, 8'h06 | 8'(ph));
      wr(1'b0, 8'(ph));
      pend = 1'b0;
      old_g = 8'hFF;
      for (int i = 0; i < 25; i++) begin
        k = 8'($urandom);
        key_in = k;
        wait_cyc(4);
        new_g = k | ~en;
        pend = pend | exp_fall(old_g, new_g) | ((ph == 1) & exp_low(new_g));
        chk_pend(ph == 0 ? "R4 random edge" : "R8 random level", pend);
        check("R7 random irq", {7'b0, irq_out}, {7'b0, pend});
        if ($urandom % 2 == 1) begin
          wr(1'b0, 8'h04 | 8'(ph));
          pend = (ph == 1) & exp_low(new_g);
          chk_pend(ph == 0 ? "R5 random ack" : "R8 random ack", pend);
          wait_cyc(2);
        end
        old_g = new_g;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule